// File: doc/BRIEF.md
# Peripheral Bring-Up Handshake Controller

This block is a host-side controller that walks a register-mapped peripheral through its start-up handshake as soon as reset is released. It drives a simple parallel register bus with an address, a write-enable, write data, a strobe and an acknowledge, and reads back a data byte. Each access is a single transaction, and only one is in flight at a time.

The controller reads the peripheral's command register over and over until the register's low six bits read zero. That value shows that the peripheral has finished its own internal start-up. The controller then writes 80h to the page register, which arms detection of the host interface. It reads the command register once more to confirm, and a zero in the low six bits means the interface came up. Last, it writes 00h to the page register, which puts the peripheral in linear addressing mode, and then raises `done`.

A failed confirmation stops the controller with `error` set. A programmable limit on the number of polls can also stop it with `error` and `timedOut` set.

Top module: `periph_bringup_ctrl`

## Requirements
- R1: While reset is active, `busStb`, `done` and `error` are low. The first transaction after reset is a read (`busWe`=0) of the command register at address 01h.
- R2: The controller keeps reading the command register until a read returns zero in bits 5:0. Bits 7:6 of the read data are ignored, so 40h, 80h and C0h all count as zero.
- R3: Right after the poll that ends the loop, the controller writes 80h to the page register at address 00h. Every write it issues goes to address 00h with data 80h or 00h.
- R4: After the 80h write, the controller reads the command register once, as the confirmation read.
- R5: If the confirmation read is zero in bits 5:0, the controller writes 00h to address 00h and then raises `done`. `done` stays high and no further strobe is issued until reset.
- R6: If the confirmation read is nonzero in bits 5:0, the controller raises `error` with `done` and `timedOut` low. `error` stays high and no further strobe is issued.
- R7: When `pollLimit` is L ≥ 1 and L polls in a row read nonzero, the controller raises `error` and `timedOut` after exactly L reads. A zero on the L-th read still counts as success.
- R8: When `pollLimit` is 0, polling has no limit and no timeout occurs.
- R9: While `busStb` is high and `busAck` is low, `busStb`, `busAddr`, `busWe` and `busWrData` hold their values. In the cycle after an acknowledged cycle, `busStb` is low.
- R10: `done` and `error` are never high together, and `timedOut` is high only together with `error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; the sequence starts when it is released |
| pollLimit | input | CNT_W (16) | Maximum number of nonzero polls before a timeout; 0 means no limit |
| busAddr | output | ADDR_W (6) | Register address of the current transaction |
| busWe | output | 1 | 1 for a write, 0 for a read |
| busWrData | output | DATA_W (8) | Write data |
| busStb | output | 1 | Transaction request, held until acknowledged |
| busAck | input | 1 | Peripheral acknowledge; completes the transaction in the cycle it is high with `busStb` |
| busRdData | input | DATA_W (8) | Read data, valid while `busAck` is high |
| done | output | 1 | Sequence finished successfully |
| error | output | 1 | Sequence stopped on a failed confirmation or a timeout |
| timedOut | output | 1 | The error was caused by the poll limit |

## Verification
Most faults in the sequencing state show up at the bus first. If the state is wrong, the next strobe carries the wrong address, write-enable or data, and the scoreboard catches it on the first acknowledged cycle after the fault. That is within the peripheral's acknowledge latency plus one gap cycle. A wrong decision on the read data, such as comparing all eight bits or counting failed polls wrongly, changes how many transactions are issued. That shows up as an extra or missing item in the expected sequence, or as a wrong `done`, `error` or `timedOut` value once the run settles. The terminal states are checked by watching the bus for several cycles after the flags rise, so a controller that keeps issuing strobes is caught.

// File: rtl/bringup_pkg.sv
package bringup_pkg;

  typedef enum logic [2:0] {
    ST_POLL = 3'd0,
    ST_ARM  = 3'd1,
    ST_CONF = 3'd2,
    ST_LIN  = 3'd3,
    ST_DONE = 3'd4,
    ST_ERR  = 3'd5
  } seqStateT;

  // strobes from the control to the datapath
  typedef struct packed {
    logic selCmdRd;  // load a command-register read
    logic selArmWr;  // load the detection-arming page write
    logic selLinWr;  // load the linear-addressing page write
    logic cntInc;    // one more failed poll
  } dpCtrlT;

endpackage

// File: rtl/bringup_datapath.sv
module bringup_datapath
  import bringup_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8,
  parameter int CMD_BITS = 6,
  parameter int CNT_W    = 16,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 6'h01,
  parameter logic [ADDR_W-1:0] PAGE_ADDR = 6'h00,
  parameter logic [DATA_W-1:0] ARM_VAL   = 8'h80,
  parameter logic [DATA_W-1:0] LIN_VAL   = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrlT            dpCtrl,
  input  logic [CNT_W-1:0]  pollLimit,
  input  logic [DATA_W-1:0] busRdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busWe,
  output logic [DATA_W-1:0] busWrData,
  output logic              cmdZero,
  output logic              limitHit
);

  localparam int CW1 = CNT_W + 1;

  logic [ADDR_W-1:0] addrQ;
  logic              weQ;
  logic [DATA_W-1:0] wdatQ;
  logic [CNT_W-1:0]  failCntQ;
  logic [CW1-1:0]    failsAfter;

  // Transaction fields: reset selects a command-register read.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= CMD_ADDR;
      weQ   <= 1'b0;
      wdatQ <= '0;
    end else if (dpCtrl.selCmdRd) begin
      addrQ <= CMD_ADDR;
      weQ   <= 1'b0;
      wdatQ <= '0;
    end else if (dpCtrl.selArmWr) begin
      addrQ <= PAGE_ADDR;
      weQ   <= 1'b1;
      wdatQ <= ARM_VAL;
    end else if (dpCtrl.selLinWr) begin
      addrQ <= PAGE_ADDR;
      weQ   <= 1'b1;
      wdatQ <= LIN_VAL;
    end
  end

  // Failed-poll counter, saturating.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      failCntQ <= '0;
    end else if (dpCtrl.cntInc && (failCntQ != '1)) begin
      failCntQ <= failCntQ + CNT_W'(1);
    end
  end

  assign failsAfter = {1'b0, failCntQ} + CW1'(1);
  assign limitHit   = (pollLimit != '0) && (failsAfter >= {1'b0, pollLimit});

  // Only the low command bits take part in the comparison.
  assign cmdZero = (busRdData[CMD_BITS-1:0] == '0);

  generate
    if (CMD_BITS < DATA_W) begin : g_upperIgnored
      logic unusedUpper;
      assign unusedUpper = ^busRdData[DATA_W-1:CMD_BITS];
    end
  endgenerate

  assign busAddr   = addrQ;
  assign busWe     = weQ;
  assign busWrData = wdatQ;

endmodule

// File: rtl/bringup_control.sv
module bringup_control
  import bringup_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   busAck,
  input  logic   cmdZero,
  input  logic   limitHit,
  output dpCtrlT dpCtrl,
  output logic   busStb,
  output logic   done,
  output logic   error,
  output logic   timedOut
);

  seqStateT stateQ, stateD;
  logic     gapQ, gapD;
  logic     toQ, toD;
  logic     inTxn;
  logic     handshake;

  assign inTxn = (stateQ == ST_POLL) || (stateQ == ST_ARM) ||
                 (stateQ == ST_CONF) || (stateQ == ST_LIN);
  assign busStb    = inTxn && !gapQ;
  assign handshake = busStb && busAck;

  always_comb begin
    stateD = stateQ;
    gapD   = 1'b0;
    toD    = toQ;
    dpCtrl = '0;
    case (stateQ)
      ST_POLL: begin
        if (handshake) begin
          gapD = 1'b1;
          if (cmdZero) begin
            stateD          = ST_ARM;
            dpCtrl.selArmWr = 1'b1;
          end else if (limitHit) begin
            stateD = ST_ERR;
            toD    = 1'b1;
          end else begin
            dpCtrl.cntInc = 1'b1;
          end
        end
      end
      ST_ARM: begin
        if (handshake) begin
          gapD            = 1'b1;
          stateD          = ST_CONF;
          dpCtrl.selCmdRd = 1'b1;
        end
      end
      ST_CONF: begin
        if (handshake) begin
          gapD = 1'b1;
          if (cmdZero) begin
            stateD          = ST_LIN;
            dpCtrl.selLinWr = 1'b1;
          end else begin
            stateD = ST_ERR;
          end
        end
      end
      ST_LIN: begin
        if (handshake) begin
          gapD   = 1'b1;
          stateD = ST_DONE;
        end
      end
      default: begin
        stateD = stateQ;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_POLL;
      gapQ   <= 1'b1;
      toQ    <= 1'b0;
    end else begin
      stateQ <= stateD;
      gapQ   <= gapD;
      toQ    <= toD;
    end
  end

  assign done     = (stateQ == ST_DONE);
  assign error    = (stateQ == ST_ERR);
  assign timedOut = toQ;

endmodule

// File: rtl/periph_bringup_ctrl.sv
module periph_bringup_ctrl
  import bringup_pkg::*;
#(
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 8,
  parameter int CMD_BITS = 6,
  parameter int CNT_W    = 16,
  parameter logic [ADDR_W-1:0] CMD_ADDR  = 6'h01,
  parameter logic [ADDR_W-1:0] PAGE_ADDR = 6'h00,
  parameter logic [DATA_W-1:0] ARM_VAL   = 8'h80,
  parameter logic [DATA_W-1:0] LIN_VAL   = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  pollLimit,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busWe,
  output logic [DATA_W-1:0] busWrData,
  output logic              busStb,
  input  logic              busAck,
  input  logic [DATA_W-1:0] busRdData,
  output logic              done,
  output logic              error,
  output logic              timedOut
);

  dpCtrlT dpCtrl;
  logic   cmdZero;
  logic   limitHit;

  bringup_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .busAck   (busAck),
    .cmdZero  (cmdZero),
    .limitHit (limitHit),
    .dpCtrl   (dpCtrl),
    .busStb   (busStb),
    .done     (done),
    .error    (error),
    .timedOut (timedOut)
  );

  bringup_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CMD_BITS  (CMD_BITS),
    .CNT_W     (CNT_W),
    .CMD_ADDR  (CMD_ADDR),
    .PAGE_ADDR (PAGE_ADDR),
    .ARM_VAL   (ARM_VAL),
    .LIN_VAL   (LIN_VAL)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .dpCtrl    (dpCtrl),
    .pollLimit (pollLimit),
    .busRdData (busRdData),
    .busAddr   (busAddr),
    .busWe     (busWe),
    .busWrData (busWrData),
    .cmdZero   (cmdZero),
    .limitHit  (limitHit)
  );

endmodule

// File: rtl/periph_bringup_ctrl_chk.sv
module periph_bringup_ctrl_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] PAGE_ADDR = 6'h00,
  parameter logic [DATA_W-1:0] ARM_VAL   = 8'h80,
  parameter logic [DATA_W-1:0] LIN_VAL   = 8'h00
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [DATA_W-1:0] busWrData,
  input logic              busStb,
  input logic              busAck,
  input logic              done,
  input logic              error,
  input logic              timedOut
);

  p_stb_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busStb && !busAck) |=> (busStb && $stable(busAddr) && $stable(busWe) && $stable(busWrData)));

  p_gap_after_ack_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busStb && busAck) |=> !busStb);

  p_write_target_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busStb && busWe) |-> ((busAddr == PAGE_ADDR) && ((busWrData == ARM_VAL) || (busWrData == LIN_VAL))));

  p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done);

  p_error_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    error |=> error);

  p_quiet_end_r5: assert property (@(posedge clk) disable iff (!rstN)
    (done || error) |-> !busStb);

  p_exclusive_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error));

  p_timeout_is_error_r10: assert property (@(posedge clk) disable iff (!rstN)
    timedOut |-> error);

endmodule

bind periph_bringup_ctrl periph_bringup_ctrl_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .PAGE_ADDR (PAGE_ADDR),
  .ARM_VAL   (ARM_VAL),
  .LIN_VAL   (LIN_VAL)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWe     (busWe),
  .busWrData (busWrData),
  .busStb    (busStb),
  .busAck    (busAck),
  .done      (done),
  .error     (error),
  .timedOut  (timedOut)
);

// File: tb/periph_bringup_ctrl_bench.sv
`timescale 1ns/1ps
module periph_bringup_ctrl_bench;

  localparam logic [5:0] CMD_A  = 6'h01;
  localparam logic [5:0] PAGE_A = 6'h00;

  typedef struct {
    logic [5:0] addr;
    logic       we;
    logic [7:0] data;
    string      tag;
  } txnT;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] pollLimit = 16'd0;
  logic [5:0]  busAddr;
  logic        busWe;
  logic [7:0]  busWrData;
  logic        busStb;
  logic        busAck = 1'b0;
  logic [7:0]  busRdData = 8'h00;
  logic        done, error, timedOut;

  int nCmp = 0;
  int nBad = 0;
  int ackLat = 0;
  int waitCnt = 0;
  txnT        expQ[$];
  logic [7:0] script[$];

  always #2.5 clk = ~clk;

  periph_bringup_ctrl u_periph_bringup_ctrl (
    .clk(clk), .rstN(rstN), .pollLimit(pollLimit),
    .busAddr(busAddr), .busWe(busWe), .busWrData(busWrData),
    .busStb(busStb), .busAck(busAck), .busRdData(busRdData),
    .done(done), .error(error), .timedOut(timedOut)
  );

  // Responder standing in for the peripheral.
  always @(posedge clk) begin
    if (!rstN) begin
      busAck  <= 1'b0;
      waitCnt <= 0;
    end else if (busAck) begin
      busAck  <= 1'b0;
      waitCnt <= 0;
    end else if (busStb) begin
      if (waitCnt >= ackLat) begin
        busAck <= 1'b1;
        if (!busWe && busAddr == CMD_A)
          busRdData <= (script.size() > 0) ? script.pop_front() : 8'h00;
        else
          busRdData <= 8'hFF;
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end
  end

  // Monitor: compare each acknowledged transaction against the queue.
  always @(negedge clk) begin
    if (rstN && busStb && busAck) begin
      nCmp++;
      if (expQ.size() == 0) begin
        nBad++;
        $display("FAIL R5/R6/R7 unexpected txn addr=%h we=%0d data=%h expected none",
                 busAddr, busWe, busWrData);
      end else begin
        txnT e;
        e = expQ.pop_front();
        if (busAddr !== e.addr || busWe !== e.we || busWrData !== e.data) begin
          nBad++;
          $display("FAIL %s addr/we/data=%h/%0d/%h expected %h/%0d/%h",
                   e.tag, busAddr, busWe, busWrData, e.addr, e.we, e.data);
        end
      end
    end
  end

  task automatic expectTxn(input logic [5:0] a, input logic w, input logic [7:0] d, input string tag);
    txnT t;
    t.addr = a; t.we = w; t.data = d; t.tag = tag;
    expQ.push_back(t);
  endtask

  task automatic checkVal(input string tag, input logic [31:0] act, input logic [31:0] expv);
    nCmp++;
    if (act !== expv) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic runCase(input string name, input logic [15:0] lim, input int lat,
                         input logic expDone, input logic expErr, input logic expTo);
    @(negedge clk);
    rstN = 1'b0;
    pollLimit = lim;
    ackLat = lat;
    repeat (3) @(negedge clk);
    checkVal({name, " R1 stb in reset"}, busStb, 0);
    checkVal({name, " R1 done in reset"}, done, 0);
    checkVal({name, " R1 error in reset"}, error, 0);
    rstN = 1'b1;
    for (int i = 0; i < 2000 && !(done || error); i++) @(negedge clk);
    repeat (12) @(negedge clk);
    checkVal({name, " R5 done"}, done, expDone);
    checkVal({name, " R6 error"}, error, expErr);
    checkVal({name, " R7 timedOut"}, timedOut, expTo);
    checkVal({name, " R9 no strobe at end"}, busStb, 0);
    checkVal({name, " R5/R6/R7 missing txns"}, expQ.size(), 0);
    expQ.delete();
    script.delete();
  endtask

  initial begin
    fork
      begin
        // A: mixed polls, upper bits ignored on C0h, full success
        script = '{8'h3F, 8'h3F, 8'h05, 8'hC0, 8'h00};
        for (int i = 0; i < 4; i++) expectTxn(CMD_A, 1'b0, 8'h00, "R1/R2 poll read");
        expectTxn(PAGE_A, 1'b1, 8'h80, "R3 arm write");
        expectTxn(CMD_A, 1'b0, 8'h00, "R4 confirm read");
        expectTxn(PAGE_A, 1'b1, 8'h00, "R5 linear write");
        runCase("caseA", 16'd10, 1, 1'b1, 1'b0, 1'b0);

        // B: confirmation fails
        script = '{8'h00, 8'h01};
        expectTxn(CMD_A, 1'b0, 8'h00, "R1 poll read");
        expectTxn(PAGE_A, 1'b1, 8'h80, "R3 arm write");
        expectTxn(CMD_A, 1'b0, 8'h00, "R6 confirm read");
        runCase("caseB", 16'd4, 0, 1'b0, 1'b1, 1'b0);

        // C: timeout after exactly 3 polls
        script = '{8'h3F, 8'h3F, 8'h3F, 8'h3F, 8'h3F};
        for (int i = 0; i < 3; i++) expectTxn(CMD_A, 1'b0, 8'h00, "R7 poll read");
        runCase("caseC", 16'd3, 2, 1'b0, 1'b1, 1'b1);

        // D: unlimited polling
        script = '{8'h12, 8'h12, 8'h12, 8'h12, 8'h12, 8'h12, 8'h12, 8'h00, 8'h00};
        for (int i = 0; i < 8; i++) expectTxn(CMD_A, 1'b0, 8'h00, "R8 poll read");
        expectTxn(PAGE_A, 1'b1, 8'h80, "R3 arm write");
        expectTxn(CMD_A, 1'b0, 8'h00, "R4 confirm read");
        expectTxn(PAGE_A, 1'b1, 8'h00, "R5 linear write");
        runCase("caseD", 16'd0, 3, 1'b1, 1'b0, 1'b0);

        // E: limit 1, upper bits set on both reads
        script = '{8'h40, 8'h80};
        expectTxn(CMD_A, 1'b0, 8'h00, "R2 poll read");
        expectTxn(PAGE_A, 1'b1, 8'h80, "R3 arm write");
        expectTxn(CMD_A, 1'b0, 8'h00, "R2 confirm read");
        expectTxn(PAGE_A, 1'b1, 8'h00, "R5 linear write");
        runCase("caseE", 16'd1, 0, 1'b1, 1'b0, 1'b0);

        // F: limit 1, first poll nonzero
        script = '{8'h01};
        expectTxn(CMD_A, 1'b0, 8'h00, "R7 poll read");
        runCase("caseF", 16'd1, 1, 1'b0, 1'b1, 1'b1);

        // G: zero arrives on the L-th poll, still success
        script = '{8'h3F, 8'h3F, 8'h00, 8'h00};
        for (int i = 0; i < 3; i++) expectTxn(CMD_A, 1'b0, 8'h00, "R7 boundary poll");
        expectTxn(PAGE_A, 1'b1, 8'h80, "R3 arm write");
        expectTxn(CMD_A, 1'b0, 8'h00, "R4 confirm read");
        expectTxn(PAGE_A, 1'b1, 8'h00, "R5 linear write");
        runCase("caseG", 16'd3, 2, 1'b1, 1'b0, 1'b0);
      end
      begin
        repeat (100000) @(posedge clk);
        nBad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule